// File: doc/BRIEF.md
# Pin-Limited Transaction Link Between a Bus Interface Chip and Video Logic

This block joins two chips over a narrow point-to-point link that carries a trimmed-down PCI-style transaction set. The host side is fed decoded transactions, one beat per cycle: an address phase followed by data phases. It drives them onto a 32-bit multiplexed address/data bus, three command/byte-lane lines and a transfer-valid strobe. The target side rebuilds address, command, data and byte-lane mask for the register logic. It also lets the register logic send single words back: it raises a request line, waits for a grant and then returns the word.

The link uses 38 wires including the clock. These are 32 shared address/data lines, 3 command/lane lines, the transfer-valid strobe (`irdy`), the send-request strobe (`trdy`) and the clock. The return word uses the same address/data pins during a cycle the host leaves free. In the model these pins appear as two one-way buses. Nothing else shares the link, so the link has no device select and no separate start-of-frame line. The first strobe-high cycle after a low one is the address phase, and the target can never refuse a transfer. A parameterised number of register stages in each direction models the buffering the board-level wires need.

Top module: `rbridge_link`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every output of the block is zero.
- R2: With S = `LINK_STAGES`, an address phase is a cycle with `h_vld` high that follows a cycle with `h_vld` low. If its command is supported, `t_avld` pulses for one cycle S+1 cycles later. `t_addr` then carries `h_ad[30:0]`, and `t_io` carries `h_ad[31]` (1 = IO space, 0 = memory space).
- R3: Only two command codes on `h_cbe` are supported: 3'b010 is a read and 3'b011 is a write. `t_wr` is 1 for a write and 0 for a read. The value is held until the next supported address phase.
- R4: An address phase with any other code raises `t_err` for exactly one cycle, S+1 cycles later. No `t_avld` follows, and the data phases and end of that burst produce no `t_dvld` and no `t_last`.
- R5: Each `h_vld`-high cycle that directly follows another `h_vld`-high cycle is a data phase. In a supported burst, each data phase gives a one-cycle `t_dvld` S+1 cycles later. `t_data` carries `h_ad`. `t_be` carries the mask {`h_cbe[2]`, `h_cbe[2]`, `h_cbe[1]`, `h_cbe[0]`}, where bit k enables byte lane k.
- R6: In a supported burst, the first `h_vld`-low cycle ends the burst, and `t_last` pulses for one cycle S+1 cycles later. A burst with no data phases still ends this way. One idle cycle between two bursts is enough to start a new address phase.
- R7: If `t_send` is high while no send is pending, `t_sdata` is captured and the target asks to send. The host grants on the first cycle, from S+1 cycles later onward, in which `h_vld` is low. After the grant on cycle g, `h_rvld` pulses for one cycle with the word on `h_rdata` 2S+2 cycles later. `h_rdata` holds the word afterwards.
- R8: A host transaction beat always wins over a pending grant. While `h_vld` stays high, no word is returned.
- R9: If `t_send` is high while a send is still pending (up to and including the cycle the target sees the grant), it is ignored. The word that arrives at `h_rvld` is the first one.
- R10: A grant cycle on the link is not seen as a transfer: it causes no `t_avld`, `t_dvld`, `t_last` or `t_err` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| h_vld | input | 1 | Host beat valid; the first high cycle of a run is the address phase |
| h_ad | input | 32 | Host address (bit 31 = IO space) or data word |
| h_cbe | input | 3 | Command code in the address phase, byte-lane enables in data phases |
| h_rvld | output | 1 | One-cycle pulse: a word returned by the target is on h_rdata |
| h_rdata | output | 32 | Last word returned by the target |
| t_avld | output | 1 | One-cycle pulse: a supported address phase arrived |
| t_addr | output | 31 | Address of the last supported transaction |
| t_io | output | 1 | 1 when the last supported transaction is in IO space |
| t_wr | output | 1 | 1 when the last supported transaction is a write |
| t_dvld | output | 1 | One-cycle pulse: a data phase arrived |
| t_data | output | 32 | Data of the last data phase |
| t_be | output | 4 | Byte-lane mask of the last data phase |
| t_last | output | 1 | One-cycle pulse: the current supported burst ended |
| t_err | output | 1 | One-cycle pulse: an address phase carried an unsupported command |
| t_send | input | 1 | Target request to return one word |
| t_sdata | input | 32 | Word to return, sampled with t_send |

## Verification
The forward path is driven with several kinds of burst, which together separate the address-phase, data-phase and end-of-burst decoding:
- memory writes with several data beats and changing lane patterns;
- an IO read with a single beat;
- a burst that is only an address phase;
- a burst with an unsupported command that still carries data;
- bursts separated by a single idle cycle;
- a long stretch of randomised bursts.

The return path is tried in three situations:
- the host is idle, which fixes the exact round-trip latency;
- a long host burst is in progress, which shows whether the grant is deferred;
- a second request arrives while the first is pending, which shows whether the second is ignored.

A cycle-accurate behavioural model predicts every output on every cycle. A wrong latency, a wrong mask bit or a pulse caused by a grant therefore shows up at once.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int AD_W  = 32;
  localparam int CBE_W = 3;
  localparam int BE_W  = 4;

  localparam logic [CBE_W-1:0] CMD_RD   = 3'b010;
  localparam logic [CBE_W-1:0] CMD_WR   = 3'b011;
  localparam logic [CBE_W-1:0] CODE_IDL = 3'b000;
  localparam logic [CBE_W-1:0] CODE_GNT = 3'b111;

  // ad + cbe + irdy + trdy + clock
  localparam int LINK_PINS = AD_W + CBE_W + 3;
endpackage

// File: rtl/rb_pipe.sv
module rb_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
          st[0] <= d;
          for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
      end
      assign q = st[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rb_host.sv
module rb_host
  import rb_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             h_vld,
  input  logic [AD_W-1:0]  h_ad,
  input  logic [CBE_W-1:0] h_cbe,
  input  logic             l_trdy,
  input  logic [AD_W-1:0]  l_bad,
  output logic             l_irdy,
  output logic [AD_W-1:0]  l_ad,
  output logic [CBE_W-1:0] l_cbe,
  output logic             h_rvld,
  output logic [AD_W-1:0]  h_rdata
);
  localparam int RT = 2 * STAGES + 2;

  logic [RT-1:0] wait_sr;
  logic          gnt;

  assign gnt = !h_vld && l_trdy && !(|wait_sr);

  always_ff @(posedge clk) begin
    if (rst) begin
      l_irdy  <= 1'b0;
      l_ad    <= '0;
      l_cbe   <= CODE_IDL;
      wait_sr <= '0;
      h_rvld  <= 1'b0;
      h_rdata <= '0;
    end else begin
      l_irdy  <= h_vld;
      l_ad    <= h_vld ? h_ad : '0;
      l_cbe   <= h_vld ? h_cbe : (gnt ? CODE_GNT : CODE_IDL);
      wait_sr <= {wait_sr[RT-2:0], gnt};
      h_rvld  <= wait_sr[RT-1];
      if (wait_sr[RT-1]) h_rdata <= l_bad;
    end
  end
endmodule

// File: rtl/rb_tgt.sv
module rb_tgt
  import rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             l_irdy,
  input  logic [AD_W-1:0]  l_ad,
  input  logic [CBE_W-1:0] l_cbe,
  input  logic             t_send,
  input  logic [AD_W-1:0]  t_sdata,
  output logic             l_trdy,
  output logic [AD_W-1:0]  l_bad,
  output logic             t_avld,
  output logic [AD_W-2:0]  t_addr,
  output logic             t_io,
  output logic             t_wr,
  output logic             t_dvld,
  output logic [AD_W-1:0]  t_data,
  output logic [BE_W-1:0]  t_be,
  output logic             t_last,
  output logic             t_err
);
  logic            in_b, drop, pend;
  logic [AD_W-1:0] sbuf;
  logic            addr_ph, data_ph, sup, gnt_seen;

  assign addr_ph  = l_irdy && !in_b;
  assign data_ph  = l_irdy && in_b;
  assign sup      = (l_cbe == CMD_RD) || (l_cbe == CMD_WR);
  assign gnt_seen = !l_irdy && (l_cbe == CODE_GNT);
  assign l_trdy   = pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_b   <= 1'b0;
      drop   <= 1'b0;
      t_avld <= 1'b0;
      t_err  <= 1'b0;
      t_dvld <= 1'b0;
      t_last <= 1'b0;
      t_addr <= '0;
      t_io   <= 1'b0;
      t_wr   <= 1'b0;
      t_data <= '0;
      t_be   <= '0;
      pend   <= 1'b0;
      sbuf   <= '0;
      l_bad  <= '0;
    end else begin
      in_b   <= l_irdy;
      t_avld <= addr_ph && sup;
      t_err  <= addr_ph && !sup;
      t_dvld <= data_ph && !drop;
      t_last <= in_b && !l_irdy && !drop;
      if (addr_ph) drop <= !sup;
      if (addr_ph && sup) begin
        t_addr <= l_ad[AD_W-2:0];
        t_io   <= l_ad[AD_W-1];
        t_wr   <= (l_cbe == CMD_WR);
      end
      if (data_ph && !drop) begin
        t_data <= l_ad;
        t_be   <= {l_cbe[2], l_cbe[2], l_cbe[1], l_cbe[0]};
      end
      if (!pend && t_send) begin
        pend <= 1'b1;
        sbuf <= t_sdata;
      end else if (pend && gnt_seen) begin
        pend  <= 1'b0;
        l_bad <= sbuf;
      end
    end
  end
endmodule

// File: rtl/rbridge_link.sv
module rbridge_link
  import rb_pkg::*;
#(
  parameter int LINK_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             h_vld,
  input  logic [AD_W-1:0]  h_ad,
  input  logic [CBE_W-1:0] h_cbe,
  output logic             h_rvld,
  output logic [AD_W-1:0]  h_rdata,
  output logic             t_avld,
  output logic [AD_W-2:0]  t_addr,
  output logic             t_io,
  output logic             t_wr,
  output logic             t_dvld,
  output logic [AD_W-1:0]  t_data,
  output logic [BE_W-1:0]  t_be,
  output logic             t_last,
  output logic             t_err,
  input  logic             t_send,
  input  logic [AD_W-1:0]  t_sdata
);
  localparam int FW = 1 + AD_W + CBE_W;
  localparam int BW = 1 + AD_W;

  logic             hi_irdy, ti_irdy, ht_trdy, tt_trdy;
  logic [AD_W-1:0]  hi_ad, ti_ad, ht_bad, tt_bad;
  logic [CBE_W-1:0] hi_cbe, ti_cbe;

  rb_host #(.STAGES(LINK_STAGES)) u_host (
    .clk(clk), .rst(rst), .h_vld(h_vld), .h_ad(h_ad), .h_cbe(h_cbe),
    .l_trdy(ht_trdy), .l_bad(ht_bad),
    .l_irdy(hi_irdy), .l_ad(hi_ad), .l_cbe(hi_cbe),
    .h_rvld(h_rvld), .h_rdata(h_rdata)
  );

  rb_pipe #(.W(FW), .STAGES(LINK_STAGES)) u_fwd (
    .clk(clk), .rst(rst),
    .d({hi_irdy, hi_ad, hi_cbe}),
    .q({ti_irdy, ti_ad, ti_cbe})
  );

  rb_pipe #(.W(BW), .STAGES(LINK_STAGES)) u_back (
    .clk(clk), .rst(rst),
    .d({tt_trdy, tt_bad}),
    .q({ht_trdy, ht_bad})
  );

  rb_tgt u_tgt (
    .clk(clk), .rst(rst),
    .l_irdy(ti_irdy), .l_ad(ti_ad), .l_cbe(ti_cbe),
    .t_send(t_send), .t_sdata(t_sdata),
    .l_trdy(tt_trdy), .l_bad(tt_bad),
    .t_avld(t_avld), .t_addr(t_addr), .t_io(t_io), .t_wr(t_wr),
    .t_dvld(t_dvld), .t_data(t_data), .t_be(t_be),
    .t_last(t_last), .t_err(t_err)
  );
endmodule

// File: rtl/rb_link_chk.sv
module rb_link_chk (
  input logic clk,
  input logic rst,
  input logic t_avld,
  input logic t_err,
  input logic t_dvld,
  input logic t_last,
  input logic h_rvld
);
  // R2
  avld_gap_chk: assert property (@(posedge clk) disable iff (rst)
    t_avld |=> !t_avld);
  // R4
  err_drop_chk: assert property (@(posedge clk) disable iff (rst)
    t_err |=> !t_dvld && !t_last);
  // R5
  data_follows_chk: assert property (@(posedge clk) disable iff (rst)
    t_dvld |-> $past(t_avld || t_dvld));
  // R6
  last_follows_chk: assert property (@(posedge clk) disable iff (rst)
    t_last |-> $past(t_avld || t_dvld));
  // R7
  rvld_single_chk: assert property (@(posedge clk) disable iff (rst)
    h_rvld |=> !h_rvld);
endmodule

bind rbridge_link rb_link_chk u_chk (
  .clk(clk), .rst(rst), .t_avld(t_avld), .t_err(t_err),
  .t_dvld(t_dvld), .t_last(t_last), .h_rvld(h_rvld)
);

// File: tb/tb_rbridge_link.sv
module tb_rbridge_link;
  localparam int S = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_vld = 1'b0;
  logic [31:0] h_ad = '0;
  logic [2:0]  h_cbe = '0;
  logic        t_send = 1'b0;
  logic [31:0] t_sdata = '0;
  logic        h_rvld, t_avld, t_io, t_wr, t_dvld, t_last, t_err;
  logic [31:0] h_rdata, t_data;
  logic [30:0] t_addr;
  logic [3:0]  t_be;

  always #2.5 clk = ~clk;

  rbridge_link #(.LINK_STAGES(S)) dut (.*);

  int vecs = 0, errs = 0, ncyc = 0;

  // reference model state
  logic        e_avld = 0, e_io = 0, e_wr = 0, e_dvld = 0, e_last = 0, e_err = 0, e_rvld = 0;
  logic [30:0] e_addr = '0;
  logic [31:0] e_data = '0, e_rdata = '0;
  logic [3:0]  e_be = '0;
  bit          m_inb = 0, m_drop = 0, m_pend = 0, m_gnt = 0;
  int          m_req = 0, m_g = 0;
  logic [31:0] m_word = '0;
  int          rv_cyc[$];
  logic [31:0] rv_dat[$];
  bit          r_v[16], r_av[16], r_er[16], r_dv[16], r_la[16], r_io[16], r_wr[16];
  logic [30:0] r_ad[16];
  logic [31:0] r_dt[16];
  logic [3:0]  r_be[16];

  always @(posedge clk) begin
    if (rst) begin
      ncyc = 0;
      for (int i = 0; i < 16; i++) r_v[i] = 0;
    end else begin
      int k, j;
      bit sup;
      ncyc++;
      k = ncyc % 16;
      e_avld = 0; e_err = 0; e_dvld = 0; e_last = 0; e_rvld = 0;
      if (r_v[k]) begin
        r_v[k] = 0;
        e_avld = r_av[k]; e_err = r_er[k]; e_dvld = r_dv[k]; e_last = r_la[k];
        if (r_av[k]) begin e_addr = r_ad[k]; e_io = r_io[k]; e_wr = r_wr[k]; end
        if (r_dv[k]) begin e_data = r_dt[k]; e_be = r_be[k]; end
      end
      j = (ncyc + S + 1) % 16;
      sup = (h_cbe == 3'b010) || (h_cbe == 3'b011);
      r_v[j]  = 1;
      r_av[j] = h_vld && !m_inb && sup;
      r_er[j] = h_vld && !m_inb && !sup;
      r_dv[j] = h_vld && m_inb && !m_drop;
      r_la[j] = m_inb && !h_vld && !m_drop;
      r_ad[j] = h_ad[30:0]; r_io[j] = h_ad[31]; r_wr[j] = (h_cbe == 3'b011);
      r_dt[j] = h_ad; r_be[j] = {h_cbe[2], h_cbe[2], h_cbe[1], h_cbe[0]};
      if (h_vld && !m_inb) m_drop = !sup;
      m_inb = h_vld;
      // return path
      if (!m_pend && t_send) begin m_pend = 1; m_word = t_sdata; m_req = ncyc; end
      if (m_pend && !m_gnt && ncyc >= m_req + S + 1 && !h_vld) begin m_gnt = 1; m_g = ncyc; end
      if (m_gnt && ncyc == m_g + S + 1) begin
        m_pend = 0; m_gnt = 0;
        rv_cyc.push_back(m_g + 2*S + 2); rv_dat.push_back(m_word);
      end
      if (rv_cyc.size() > 0 && rv_cyc[0] == ncyc) begin
        e_rvld = 1; e_rdata = rv_dat[0];
        void'(rv_cyc.pop_front()); void'(rv_dat.pop_front());
      end
    end
  end

  task automatic cmp(string req, string nm, logic [31:0] a, logic [31:0] e);
    if (a !== e) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h cycle=%0d", req, nm, a, e, ncyc);
    end
  endtask

  always @(negedge clk) begin
    vecs++;
    cmp("R2", "t_avld", 32'(t_avld), 32'(e_avld));
    cmp("R2", "t_addr", 32'(t_addr), 32'(e_addr));
    cmp("R2", "t_io",   32'(t_io),   32'(e_io));
    cmp("R3", "t_wr",   32'(t_wr),   32'(e_wr));
    cmp("R4", "t_err",  32'(t_err),  32'(e_err));
    cmp("R5", "t_dvld", 32'(t_dvld), 32'(e_dvld));
    cmp("R5", "t_data", t_data,      e_data);
    cmp("R5", "t_be",   32'(t_be),   32'(e_be));
    cmp("R6", "t_last", 32'(t_last), 32'(e_last));
    cmp("R7", "h_rvld", 32'(h_rvld), 32'(e_rvld));
    cmp("R9", "h_rdata", h_rdata,    e_rdata);
  end

  task automatic beat(bit v, logic [31:0] ad, logic [2:0] c);
    @(negedge clk); h_vld = v; h_ad = ad; h_cbe = c;
  endtask

  task automatic burst(bit io, logic [30:0] a, logic [2:0] code, int nd);
    beat(1, {io, a}, code);
    for (int i = 0; i < nd; i++) beat(1, 32'hA5000000 ^ (a + 32'(i)), 3'(i + 1));
    beat(0, '0, '0);
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk); t_send = 1; t_sdata = w;
    @(negedge clk); t_send = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) beat(0, '0, '0);
  endtask

  initial begin
    repeat (4) @(negedge clk);          // R1: zeros checked during reset
    rst = 0;
    idle(3);
    burst(0, 31'h0000_1230, 3'b011, 3); // R2 R3 R5 R6 memory write
    idle(2);
    burst(1, 31'h0000_03C4, 3'b010, 1); // R2 R3 IO read
    burst(0, 31'h7FFF_FFFC, 3'b011, 0); // R6 address only, one idle gap
    burst(0, 31'h0000_0040, 3'b110, 2); // R4 unsupported code
    burst(0, 31'h0000_0080, 3'b011, 2); // R6 one-cycle gap after drop
    idle(3);
    send(32'hCAFE_0001);                // R7 R10 host idle
    idle(10);
    fork                                // R8 grant waits for long burst
      burst(0, 31'h0000_0100, 3'b011, 8);
      send(32'hBEEF_0002);
    join
    idle(10);
    send(32'h1111_0003);                // R9 second request ignored
    send(32'h2222_0004);
    idle(12);
    send(32'h3333_0005);
    idle(10);
    for (int n = 0; n < 40; n++) begin  // mixed traffic
      logic [2:0] c;
      c = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'b011 : 3'b010);
      fork
        burst(1'($urandom), 31'($urandom), c, int'($urandom % 5));
        if ($urandom % 3 == 0) send($urandom);
      join
      idle(int'($urandom % 3));
    end
    idle(15);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule